// File: doc/BRIEF.md
# Parallel LCD Bus Master

This block is the host side of a parallel display bus. A processor reaches it through a small register port: one configuration byte, two write addresses that queue a byte for the bus (one marks it as display data, the other as a command), and one address that both starts a bus read and returns the byte that read fetched. The block produces the external strobes for either of two bus styles. One style uses separate write and read strobes, active low. The other uses a single enable strobe together with a read/write direction line. The enable strobe has a programmable polarity.

Every bus cycle runs through three phases: setup, strobe and hold. Each phase lasts a fixed number of ticks from one of four prescaled clock-enable inputs, and the configuration byte picks which one. A queued byte first waits in a one-entry data slot. It moves into the bus buffer as soon as the bus is free, which means the processor can queue the next byte while the current one is still on the bus. Two status bits report the state: one says the data slot is occupied, the other says a bus cycle is running. A one-cycle interrupt request fires either early or at the end of the transfer, as the configuration selects.

Top module: `lcdb_master`

## Requirements
- R1: After reset the configuration byte reads 0x00, `irq` is 0, `lcd_wr_n`, `lcd_rd_n` and `lcd_rnw` are 1 and `lcd_en` is 0.
- R2: Configuration byte at address 0 reads as bit0 style (0 = split strobes, 1 = enable strobe), bit1 enable polarity, bit2 interrupt timing, bits 4:3 tick select, bit5 slot-busy, bit6 bus-active, bit7 zero. A byte write updates bits 4:0. A single-bit write (`reg_bwr`, bit index on `reg_bsel`, value on `reg_wdata[0]`) updates that bit. Writes to bits 7:5 have no effect.
- R3: Any write to the configuration byte, whole or single-bit, is ignored while slot-busy or bus-active is 1.
- R4: In split-strobe style a bus write drives `lcd_wr_n` low and a bus read drives `lcd_rd_n` low. The strobe stays low during the strobe phase only, and the other strobe stays high.
- R5: In enable-strobe style `lcd_wr_n` and `lcd_rd_n` stay high. `lcd_rnw` is 0 during a write cycle. With polarity 0 `lcd_en` pulses high from an idle 0. With polarity 1 it pulses low from an idle 1.
- R6: Tick-select codes 0 to 3 choose `tick_in[0]` to `tick_in[3]`. Setup, strobe and hold last SETUP_TICKS, STROBE_TICKS and HOLD_TICKS selected ticks respectively.
- R7: A write to address 1 (`lcd_rs` = 1) or address 2 (`lcd_rs` = 0) is accepted only while slot-busy is 0. An accepted byte moves to the bus buffer in the first cycle the bus is idle, and slot-busy clears at that point.
- R8: A write to address 3 queues a bus read with `lcd_rs` = 1. `lcd_din` is sampled at the end of the strobe phase. The sampled byte is then read at address 3, and slot-busy clears in the same cycle.
- R9: With interrupt timing 0, `irq` fires one cycle after a write byte is handed to the bus buffer, or one cycle after read data lands, while bus-active is still 1.
- R10: With interrupt timing 1, `irq` fires in the first cycle after the hold phase ends, when bus-active is 0. `irq` is always a single-cycle pulse.
- R11: `lcd_rs` and `lcd_dout` stay unchanged for the whole bus cycle, and bus-active reads 1 from setup through hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 4 | Prescaled clock enables, slowest last |
| reg_wr | input | 1 | Byte write strobe of the register port |
| reg_bwr | input | 1 | Single-bit write strobe for the configuration byte |
| reg_addr | input | 2 | Register address |
| reg_bsel | input | 3 | Bit index for single-bit writes |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| lcd_din | input | DW | Data from the display |
| lcd_dout | output | DW | Data to the display |
| lcd_oe | output | 1 | Output enable for `lcd_dout` |
| lcd_rs | output | 1 | Data/command select line |
| lcd_wr_n | output | 1 | Write strobe, split style |
| lcd_rd_n | output | 1 | Read strobe, split style |
| lcd_en | output | 1 | Enable strobe, enable style |
| lcd_rnw | output | 1 | Direction line, enable style |
| irq | output | 1 | Interrupt request pulse |

## Verification
The processor can write a new byte in the very cycle the slot's previous byte is handed to the bus buffer. In that cycle slot-busy is still 1, so the new byte must be dropped. Two cycles later the slot is free again. The bench provokes this with a burst of four writes on consecutive cycles while the bus is idle. It expects exactly the first and third bytes to appear on the bus, in that order, with two early interrupts.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

  localparam int NUM_TAPS = 4;
  localparam int CFG_W    = 5;
  localparam int CF_STYLE = 0;
  localparam int CF_POL   = 1;
  localparam int CF_IRQM  = 2;
  localparam int CF_CSEL  = 3;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_WDATA = 2'd1;
  localparam logic [1:0] A_WCMD  = 2'd2;
  localparam logic [1:0] A_READ  = 2'd3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  typedef struct packed {
    logic wr_n;
    logic rd_n;
    logic en;
    logic rnw;
  } pins_t;

  function automatic int unsigned phase_ticks(phase_t p, int unsigned s,
                                              int unsigned t, int unsigned h);
    case (p)
      PH_SETUP:  return s;
      PH_STROBE: return t;
      PH_HOLD:   return h;
      default:   return 1;
    endcase
  endfunction

  function automatic phase_t phase_after(phase_t p);
    case (p)
      PH_SETUP:  return PH_STROBE;
      PH_STROBE: return PH_HOLD;
      default:   return PH_IDLE;
    endcase
  endfunction

  function automatic pins_t pin_levels(logic style, logic pol, phase_t p, logic is_wr);
    pins_t q;
    logic act;
    logic busy;
    act    = (p == PH_STROBE);
    busy   = (p != PH_IDLE);
    q.wr_n = 1'b1;
    q.rd_n = 1'b1;
    q.en   = pol;
    q.rnw  = 1'b1;
    if (!style) begin
      q.wr_n = !(act && is_wr);
      q.rd_n = !(act && !is_wr);
    end else begin
      q.en  = act ? !pol : pol;
      q.rnw = !(busy && is_wr);
    end
    return q;
  endfunction

  function automatic logic [7:0] status_byte(logic xfer, logic busy, logic [CFG_W-1:0] cfg);
    return {1'b0, xfer, busy, cfg};
  endfunction

  function automatic logic irq_event(logic late, logic wr_handoff, logic rd_ready, logic bus_done);
    return late ? bus_done : (wr_handoff | rd_ready);
  endfunction

endpackage

// File: rtl/lcdb_regs.sv
module lcdb_regs
  import lcdb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_bwr,
  input  logic [1:0]       reg_addr,
  input  logic [2:0]       reg_bsel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             xfer,
  input  logic             sample_evt,
  input  logic             done_evt,
  input  logic             cyc_wr,
  input  logic [DW-1:0]    bus_din,
  output logic             launch,
  output logic             launch_wr,
  output logic             launch_rs,
  output logic [DW-1:0]    launch_data,
  output logic [CFG_W-1:0] cfg,
  output logic             busy,
  output logic             irq
);

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             pend_q, pend_wr_q, pend_rs_q, rdwait_q, irq_q;
  logic [DW-1:0]    slot_q, rd_q;
  logic             ctrl_ok, accept, rd_land;

  assign busy        = pend_q | rdwait_q;
  assign ctrl_ok     = !busy && !xfer;
  assign accept      = reg_wr && (reg_addr != A_CTRL) && !busy;
  assign launch      = pend_q && !xfer;
  assign launch_wr   = pend_wr_q;
  assign launch_rs   = pend_rs_q;
  assign launch_data = slot_q;
  assign rd_land     = sample_evt && !cyc_wr;
  assign cfg         = cfg_q;
  assign irq         = irq_q;

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_ok) begin
      if (reg_wr && reg_addr == A_CTRL) cfg_d = reg_wdata[CFG_W-1:0];
      if (reg_bwr && int'(reg_bsel) < CFG_W) cfg_d[reg_bsel] = reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      pend_q    <= 1'b0;
      pend_wr_q <= 1'b0;
      pend_rs_q <= 1'b0;
      rdwait_q  <= 1'b0;
      slot_q    <= '0;
      rd_q      <= '0;
      irq_q     <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      irq_q <= irq_event(cfg_q[CF_IRQM], launch && pend_wr_q, rd_land, done_evt);
      if (accept) begin
        pend_q    <= 1'b1;
        pend_wr_q <= (reg_addr != A_READ);
        pend_rs_q <= (reg_addr != A_WCMD);
        slot_q    <= reg_wdata;
      end else if (launch) begin
        pend_q <= 1'b0;
      end
      if (launch && !pend_wr_q) rdwait_q <= 1'b1;
      else if (rd_land)         rdwait_q <= 1'b0;
      if (rd_land) rd_q <= bus_din;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'(status_byte(xfer, busy, cfg_q));
      A_READ:  reg_rdata = rd_q;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
  import lcdb_pkg::*;
#(
  parameter int DW           = 8,
  parameter int SETUP_TICKS  = 2,
  parameter int STROBE_TICKS = 3,
  parameter int HOLD_TICKS   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          launch,
  input  logic          launch_wr,
  input  logic          launch_rs,
  input  logic [DW-1:0] launch_data,
  output phase_t        ph,
  output logic          cyc_wr,
  output logic          cyc_rs,
  output logic [DW-1:0] cyc_data,
  output logic          sample_evt,
  output logic          done_evt
);

  localparam int MAX_SH = (SETUP_TICKS > HOLD_TICKS) ? SETUP_TICKS : HOLD_TICKS;
  localparam int MAXT   = (MAX_SH > STROBE_TICKS) ? MAX_SH : STROBE_TICKS;
  localparam int CW     = $clog2(MAXT + 1);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign ph         = ph_q;
  assign last       = tick && (ph_q != PH_IDLE) &&
                      (cnt_q == CW'(phase_ticks(ph_q, SETUP_TICKS, STROBE_TICKS, HOLD_TICKS) - 1));
  assign sample_evt = last && (ph_q == PH_STROBE);
  assign done_evt   = last && (ph_q == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      cyc_wr   <= 1'b0;
      cyc_rs   <= 1'b0;
      cyc_data <= '0;
    end else if (ph_q == PH_IDLE) begin
      cnt_q <= '0;
      if (launch) begin
        ph_q     <= PH_SETUP;
        cyc_wr   <= launch_wr;
        cyc_rs   <= launch_rs;
        cyc_data <= launch_data;
      end
    end else if (last) begin
      ph_q  <= phase_after(ph_q);
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lcdb_pins.sv
module lcdb_pins
  import lcdb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          style,
  input  logic          pol,
  input  phase_t        ph,
  input  logic          cyc_wr,
  input  logic          cyc_rs,
  input  logic [DW-1:0] cyc_data,
  output logic          lcd_wr_n,
  output logic          lcd_rd_n,
  output logic          lcd_en,
  output logic          lcd_rnw,
  output logic          lcd_rs,
  output logic          lcd_oe,
  output logic [DW-1:0] lcd_dout
);

  pins_t lv;

  assign lv       = pin_levels(style, pol, ph, cyc_wr);
  assign lcd_wr_n = lv.wr_n;
  assign lcd_rd_n = lv.rd_n;
  assign lcd_en   = lv.en;
  assign lcd_rnw  = lv.rnw;
  assign lcd_rs   = cyc_rs;
  assign lcd_dout = cyc_data;
  assign lcd_oe   = (ph != PH_IDLE) && cyc_wr;

endmodule

// File: rtl/lcdb_master.sv
module lcdb_master
  import lcdb_pkg::*;
#(
  parameter int DW           = 8,
  parameter int SETUP_TICKS  = 2,
  parameter int STROBE_TICKS = 3,
  parameter int HOLD_TICKS   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] tick_in,
  input  logic                reg_wr,
  input  logic                reg_bwr,
  input  logic [1:0]          reg_addr,
  input  logic [2:0]          reg_bsel,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic [DW-1:0]       lcd_din,
  output logic [DW-1:0]       lcd_dout,
  output logic                lcd_oe,
  output logic                lcd_rs,
  output logic                lcd_wr_n,
  output logic                lcd_rd_n,
  output logic                lcd_en,
  output logic                lcd_rnw,
  output logic                irq
);

  phase_t           ph;
  logic             xfer, busy, launch, launch_wr, launch_rs;
  logic [DW-1:0]    launch_data, cyc_data;
  logic             cyc_wr, cyc_rs, sample_evt, done_evt, tick_sel;
  logic [CFG_W-1:0] cfg;

  assign xfer     = (ph != PH_IDLE);
  assign tick_sel = tick_in[cfg[CF_CSEL +: 2]];

  lcdb_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_bwr(reg_bwr), .reg_addr(reg_addr), .reg_bsel(reg_bsel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer(xfer), .sample_evt(sample_evt), .done_evt(done_evt), .cyc_wr(cyc_wr),
    .bus_din(lcd_din),
    .launch(launch), .launch_wr(launch_wr), .launch_rs(launch_rs), .launch_data(launch_data),
    .cfg(cfg), .busy(busy), .irq(irq)
  );

  lcdb_seq #(
    .DW(DW), .SETUP_TICKS(SETUP_TICKS), .STROBE_TICKS(STROBE_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_sel),
    .launch(launch), .launch_wr(launch_wr), .launch_rs(launch_rs), .launch_data(launch_data),
    .ph(ph), .cyc_wr(cyc_wr), .cyc_rs(cyc_rs), .cyc_data(cyc_data),
    .sample_evt(sample_evt), .done_evt(done_evt)
  );

  lcdb_pins #(.DW(DW)) u_pins (
    .style(cfg[CF_STYLE]), .pol(cfg[CF_POL]), .ph(ph),
    .cyc_wr(cyc_wr), .cyc_rs(cyc_rs), .cyc_data(cyc_data),
    .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_en(lcd_en), .lcd_rnw(lcd_rnw),
    .lcd_rs(lcd_rs), .lcd_oe(lcd_oe), .lcd_dout(lcd_dout)
  );

endmodule

// File: rtl/lcdb_master_chk.sv
module lcdb_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer,
  input logic          busy,
  input logic          irq,
  input logic [4:0]    cfg,
  input logic          lcd_wr_n,
  input logic          lcd_rd_n,
  input logic          lcd_en,
  input logic          lcd_rnw,
  input logic          lcd_rs,
  input logic [DW-1:0] lcd_dout
);

  logic style, pol, irqm;
  assign style = cfg[0];
  assign pol   = cfg[1];
  assign irqm  = cfg[2];

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R10
  AST_IRQ_EARLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (irq && !irqm) |-> xfer); // R9
  AST_IRQ_LATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (irq && irqm) |-> !xfer); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (xfer || busy) |=> $stable(cfg)); // R3
  AST_RS_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && $past(xfer)) |-> ($stable(lcd_rs) && $stable(lcd_dout))); // R11
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |-> (lcd_wr_n && lcd_rd_n && lcd_rnw && (lcd_en == pol))); // R5
  AST_SPLIT_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !style |-> ((lcd_wr_n || lcd_rd_n) && (lcd_en == pol) && lcd_rnw)); // R4
  AST_ENABLE_STYLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    style |-> (lcd_wr_n && lcd_rd_n)); // R5

endmodule

bind lcdb_master lcdb_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer(xfer), .busy(busy), .irq(irq), .cfg(cfg),
  .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_en(lcd_en), .lcd_rnw(lcd_rnw),
  .lcd_rs(lcd_rs), .lcd_dout(lcd_dout)
);

// File: tb/lcdb_master_tb_top.sv
module lcdb_master_tb_top;
  localparam int DW = 8;
  localparam int ST = 2;
  localparam int SB = 3;
  localparam int HD = 2;

  localparam logic [1:0] AC = 2'd0, AW = 2'd1, AK = 2'd2, AR = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    tick_in = 4'h0;
  logic          reg_wr = 1'b0, reg_bwr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [2:0]    reg_bsel = 3'd0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata, lcd_din = '0, lcd_dout;
  logic          lcd_oe, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_en, lcd_rnw, irq;

  int n_chk = 0, n_bad = 0;
  int tc = 0;
  logic cur_style = 0, cur_pol = 0, mon_en = 0, mon_on;
  int s_w = 0, m_cnt = 0, m_w = 0, gap = 0, irq_cnt = 0, irq_m = 0, irq_gap = 0;
  logic [7:0] s_d;
  logic s_rs, s_wr;
  logic [7:0] h_d [8];
  logic h_rs [8];
  logic h_wr [8];
  logic [7:0] rv;

  always #5 clk = ~clk;

  lcdb_master #(.DW(DW), .SETUP_TICKS(ST), .STROBE_TICKS(SB), .HOLD_TICKS(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr), .reg_bwr(reg_bwr),
    .reg_addr(reg_addr), .reg_bsel(reg_bsel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lcd_din(lcd_din), .lcd_dout(lcd_dout), .lcd_oe(lcd_oe), .lcd_rs(lcd_rs),
    .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_en(lcd_en), .lcd_rnw(lcd_rnw), .irq(irq)
  );

  function automatic int exp_width(int csel);
    return SB * (1 << csel);
  endfunction

  function automatic int exp_gap(logic late, int csel);
    return late ? HD * (1 << csel) : 0;
  endfunction

  function automatic logic [7:0] cfg_byte(logic st, logic po, logic im, logic [1:0] cs);
    return {3'b000, cs, im, po, st};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    tc++;
    for (int i = 0; i < 4; i++) tick_in[i] = ((tc % (1 << i)) == 0);
  end

  initial forever begin
    @(posedge clk);
    #2;
    if (!mon_en) begin
      s_w = 0;
    end else begin
      mon_on = cur_style ? (lcd_en != cur_pol) : (!lcd_wr_n || !lcd_rd_n);
      if (mon_on) begin
        s_w++;
        s_d  = lcd_dout;
        s_rs = lcd_rs;
        s_wr = cur_style ? !lcd_rnw : !lcd_wr_n;
      end else if (s_w > 0) begin
        h_d[m_cnt % 8]  = s_d;
        h_rs[m_cnt % 8] = s_rs;
        h_wr[m_cnt % 8] = s_wr;
        m_cnt++;
        m_w = s_w;
        s_w = 0;
        gap = 0;
      end
      if (irq) begin
        irq_cnt++;
        irq_m   = m_cnt;
        irq_gap = gap;
      end
      gap++;
    end
  end

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = AC;
  endtask

  task automatic cpu_bwr(input logic [2:0] b, input logic v);
    @(negedge clk);
    reg_bwr = 1'b1; reg_bsel = b; reg_wdata = {7'd0, v};
    @(negedge clk);
    reg_bwr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = AC;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      reg_addr = AC;
      #1;
      if (reg_rdata[6:5] == 2'b00) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic st, input logic po, input logic im, input logic [1:0] cs);
    mon_en = 1'b0;
    cpu_wr(AC, cfg_byte(st, po, im, cs));
    cur_style = st;
    cur_pol   = po;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic do_xfer(input logic st, input logic po, input logic im, input logic [1:0] cs,
                         input int op, input logic [7:0] d);
    int pm, pi;
    string sty;
    logic [7:0] got;
    sty = st ? "R5" : "R4";
    set_cfg(st, po, im, cs);
    pm = m_cnt;
    pi = irq_cnt;
    if (op == 2) begin
      lcd_din = d;
      cpu_wr(AR, 8'h00);
    end else begin
      cpu_wr((op == 0) ? AW : AK, d);
    end
    wait_idle();
    chk({sty, " R7 one bus cycle"}, m_cnt, pm + 1);
    chk("R6 strobe width", m_w, exp_width(int'(cs)));
    chk("R7 R8 rs level", int'(h_rs[(m_cnt + 7) % 8]), (op != 1) ? 1 : 0);
    chk({sty, " direction"}, int'(h_wr[(m_cnt + 7) % 8]), (op != 2) ? 1 : 0);
    if (op == 2) begin
      cpu_rd(AR, got);
      chk("R8 read data", int'(got), int'(d));
    end else begin
      chk({sty, " write data"}, int'(h_d[(m_cnt + 7) % 8]), int'(d));
    end
    chk("R9 R10 irq count", irq_cnt, pi + 1);
    if (!im && op != 2) begin
      chk("R9 irq before strobe", irq_m, pm);
    end else begin
      chk("R9 R10 irq after strobe", irq_m, pm + 1);
      chk(im ? "R10 irq at end" : "R9 irq at data", irq_gap, exp_gap(im, int'(cs)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pm, pi;
    logic [7:0] d;
    void'($urandom(32'h1CDB));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 cfg after reset", int'(reg_rdata), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 idle pins", int'({lcd_wr_n, lcd_rd_n, lcd_en, lcd_rnw}), 'b1101);

    // R2 single-bit and whole-byte writes, read-only bits
    cpu_bwr(3'd0, 1'b1);
    cpu_bwr(3'd3, 1'b1);
    cpu_rd(AC, d);
    chk("R2 bit writes", int'(d), 'h09);
    cpu_bwr(3'd5, 1'b1);
    cpu_bwr(3'd7, 1'b1);
    cpu_rd(AC, d);
    chk("R2 read-only bits", int'(d), 'h09);
    cpu_wr(AC, 8'hFF);
    cpu_rd(AC, d);
    chk("R2 byte write", int'(d), 'h1F);

    // directed cycles in each style and polarity
    do_xfer(1'b0, 1'b0, 1'b0, 2'd0, 0, 8'hA5);
    do_xfer(1'b0, 1'b0, 1'b1, 2'd1, 2, 8'h3C);
    do_xfer(1'b1, 1'b0, 1'b0, 2'd2, 1, 8'h96);
    do_xfer(1'b1, 1'b1, 1'b1, 2'd3, 2, 8'hE1);
    do_xfer(1'b1, 1'b1, 1'b0, 2'd0, 2, 8'h5B);

    // R3 R11 configuration frozen while the bus is active; slot fills once
    set_cfg(1'b0, 1'b0, 1'b1, 2'd3);
    pm = m_cnt;
    cpu_wr(AW, 8'h5A);
    repeat (3) @(negedge clk);
    cpu_rd(AC, d);
    chk("R11 bus-active flag", int'(d), 'h5C);
    cpu_wr(AC, 8'h00);
    cpu_bwr(3'd0, 1'b1);
    cpu_rd(AC, d);
    chk("R3 cfg ignored during transfer", int'(d), 'h5C);
    cpu_wr(AW, 8'h11);
    cpu_wr(AW, 8'h22);
    cpu_rd(AC, d);
    chk("R7 slot busy flag", int'(d), 'h7C);
    wait_idle();
    chk("R7 two cycles only", m_cnt, pm + 2);
    chk("R7 first byte", int'(h_d[pm % 8]), 'h5A);
    chk("R7 queued byte", int'(h_d[(pm + 1) % 8]), 'h11);
    cpu_rd(AC, d);
    chk("R3 cfg kept", int'(d), 'h1C);

    // R7 burst: write in the hand-off cycle is dropped
    set_cfg(1'b0, 1'b0, 1'b0, 2'd0);
    pm = m_cnt;
    pi = irq_cnt;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW;
    reg_wdata = 8'hC1; @(negedge clk);
    reg_wdata = 8'hC2; @(negedge clk);
    reg_wdata = 8'hC3; @(negedge clk);
    reg_wdata = 8'hC4; @(negedge clk);
    reg_wr = 1'b0; reg_addr = AC;
    wait_idle();
    chk("R7 burst cycles", m_cnt, pm + 2);
    chk("R7 burst first", int'(h_d[pm % 8]), 'hC1);
    chk("R7 burst third", int'(h_d[(pm + 1) % 8]), 'hC3);
    chk("R9 burst irqs", irq_cnt, pi + 2);

    // constrained random cycles
    for (int it = 0; it < 24; it++) begin
      do_xfer(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 4),
              int'($urandom % 3), 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule